// File: doc/BRIEF.md
# Hit Data Organizer with Road Lookup

This block sits between the readout of one or two tracker layers and an associative road matcher. Full-resolution hits arrive on a stream clocked by the sender's own clock. Each hit is reduced to a coarse super bin by discarding the low-order coordinate bits, which merges neighbouring channels, and is sent on a single super-bin stream to the matcher. The full hit is also kept in a store organised per layer and per super bin. Each bin holds a linked list with a head-pointer table, and a valid bit per bin marks the lists that are live.

Once an end-of-event word has passed, the block accepts matched road identifiers. A configuration table gives, for every road, the super bin it expects on each layer. For each road the block emits a packet: a header word with the road identifier, then every stored hit in the expected bins, layer 0 first. The final word of a packet carries a last flag. A terminating road word ends the event. All valid bits are then cleared in a single cycle, and the block accepts hits for the next event.

The hit, super-bin, road and packet interfaces are valid/ready streams. A word transfers on a rising edge where both valid and ready are high. A source that raises valid holds it, and holds its data unchanged, until the transfer happens. Ready may fall at any time. The configuration port is a plain write strobe.

Top module: `hit_road_organizer`

## Requirements
- R1: Every hit word (hit_eoe=0) produces exactly one super-bin word with sb_eoe=0, sb_layer equal to the hit layer and sb_bin equal to hit_coord shifted right by SB_SHIFT (2 by default). These words keep arrival order.
- R2: A hit word with hit_eoe=1 carries no hit. It produces one super-bin word with sb_eoe=1, emitted after the event's hits, and road_ready then goes high.
- R3: While sb_valid is high and sb_ready is low, sb_valid stays high and sb_eoe, sb_layer and sb_bin do not change.
- R4: A configuration write (cfg_we) records cfg_sb as the expected bin of road cfg_road on layer cfg_layer. Readout of that road uses these bins.
- R5: Each accepted road word (road_end=0) yields a packet. The first word has pkt_hdr=1 and pkt_data equal to the road id, zero-extended. Each following word has pkt_hdr=0 and pkt_data={layer, coord}. Layer 0's hits come before layer 1's, and within a bin the most recently stored hit comes first.
- R6: pkt_last is high on the final word of each packet and on no other word. A road with no stored hits in its bins yields a single header word with pkt_last=1.
- R7: The layers have separate stores. A hit on one layer never appears under another layer's bin, even when the bin numbers are equal.
- R8: An accepted road word with road_end=1 clears the store. The next event's packets hold only that event's hits.
- R9: The store holds 2^STORE_AW hits (16 by default) per event. Later hits are still sent as super-bin words but are not stored.
- R10: While pkt_valid is high and pkt_ready is low, pkt_valid stays high and pkt_hdr, pkt_last and pkt_data do not change.
- R11: Hits arriving while roads are being read out wait in the input buffer. They are forwarded, in order, only after the clear. road_ready and pkt_valid are never high together.
- R12: After reset, hit_ready is 1, and sb_valid, road_ready and pkt_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hit_clk | input | 1 | Clock of the hit input stream |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| hit_valid | input | 1 | Hit word valid (hit_clk domain) |
| hit_ready | output | 1 | Input buffer can take a word (hit_clk domain) |
| hit_eoe | input | 1 | Word is an end-of-event marker, not a hit |
| hit_layer | input | LW | Layer of the hit |
| hit_coord | input | COORD_W | Full-resolution coordinate |
| sb_valid | output | 1 | Super-bin word valid |
| sb_ready | input | 1 | Matcher accepts super-bin word |
| sb_eoe | output | 1 | Super-bin word is the end-of-event marker |
| sb_layer | output | LW | Layer of the super-bin word |
| sb_bin | output | SB_W | Coarse bin |
| road_valid | input | 1 | Road word valid |
| road_ready | output | 1 | Block accepts a road word |
| road_end | input | 1 | Road word terminates the event's road list |
| road_id | input | ROAD_W | Matched road identifier |
| pkt_valid | output | 1 | Packet word valid |
| pkt_ready | input | 1 | Downstream accepts packet word |
| pkt_hdr | output | 1 | Word is a header |
| pkt_last | output | 1 | Final word of the packet |
| pkt_data | output | PW | Road id (header) or {layer, coord} (hit) |
| cfg_we | input | 1 | Write strobe for the road table |
| cfg_road | input | ROAD_W | Road being configured |
| cfg_layer | input | LW | Layer being configured |
| cfg_sb | input | SB_W | Expected bin for that road and layer |

## Verification
Two functions can overlap. The next event's hits can arrive while the previous event's roads are still being read out, and the packet stream can be stalled in the same cycles that the lookup walks a list. The bench starts the next event's hit sender in parallel with the road sequence and toggles pkt_ready on alternate cycles. It checks that the old event's packets come out word for word as expected, and that no super-bin word for the new event appears before the terminating road word. It also checks that the new hit then shows up alone in the next event's packet. The stability properties judge every stalled cycle of both output streams.

// File: rtl/hdo_pkg.sv
package hdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_HDR,
    ST_SEEK,
    ST_HIT,
    ST_CLEAR
  } hdo_state_e;
endpackage

// File: rtl/hdo_cdc_fifo.sv
module hdo_cdc_fifo #(
  parameter int W  = 10,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data
);
  localparam int D = 1 << AW;

  logic [W-1:0] mem [D];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  rg_w1, rg_w2, wg_r1, wg_r2;
  logic [AW:0]  wbin_nx, rbin_nx;
  logic         push, pop;

  assign wr_ready = (wgray != {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
  assign push     = wr_valid && wr_ready;
  assign wbin_nx  = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign rd_valid = (rgray != wg_r2);
  assign pop      = rd_pop && rd_valid;
  assign rbin_nx  = rbin + 1'b1;
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/hdo_hit_store.sv
module hdo_hit_store #(
  parameter int NL   = 2,
  parameter int LW   = 1,
  parameter int SB_W = 6,
  parameter int CW   = 8,
  parameter int AW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [LW-1:0]           wr_layer,
  input  logic [SB_W-1:0]         wr_sb,
  input  logic [CW-1:0]           wr_coord,
  output logic                    full,
  input  logic [NL-1:0][SB_W-1:0] q_sb,
  output logic [NL-1:0]           q_v,
  output logic [NL-1:0][AW-1:0]   q_ptr,
  input  logic [AW-1:0]           rd_ptr,
  output logic [CW-1:0]           rd_coord,
  output logic                    rd_next_v,
  output logic [AW-1:0]           rd_next
);
  localparam int NB    = NL << SB_W;
  localparam int IW    = $clog2(NB);
  localparam int DEPTH = 1 << AW;

  logic [NB-1:0]   bin_v;
  logic [AW-1:0]   head   [NB];
  logic [CW-1:0]   coord_m[DEPTH];
  logic            nv_m   [DEPTH];
  logic [AW-1:0]   nx_m   [DEPTH];
  logic [AW:0]     cnt;
  logic [IW-1:0]   widx;
  logic            do_wr;

  assign full  = cnt[AW];
  assign widx  = IW'(int'(wr_layer) * (1 << SB_W) + int'(wr_sb));
  assign do_wr = wr_en && !full && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_v <= '0;
      cnt   <= '0;
    end else if (clr) begin
      bin_v <= '0;
      cnt   <= '0;
    end else if (do_wr) begin
      bin_v[widx] <= 1'b1;
      cnt         <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      coord_m[cnt[AW-1:0]] <= wr_coord;
      nv_m[cnt[AW-1:0]]    <= bin_v[widx];
      nx_m[cnt[AW-1:0]]    <= head[widx];
      head[widx]           <= cnt[AW-1:0];
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_query
    logic [IW-1:0] qidx;
    assign qidx     = IW'(l * (1 << SB_W) + int'(q_sb[l]));
    assign q_v[l]   = bin_v[qidx];
    assign q_ptr[l] = head[qidx];
  end

  assign rd_coord  = coord_m[rd_ptr];
  assign rd_next_v = nv_m[rd_ptr];
  assign rd_next   = nx_m[rd_ptr];
endmodule

// File: rtl/hdo_road_lut.sv
module hdo_road_lut #(
  parameter int NL   = 2,
  parameter int LW   = 1,
  parameter int SB_W = 6,
  parameter int RW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [RW-1:0]           cfg_road,
  input  logic [LW-1:0]           cfg_layer,
  input  logic [SB_W-1:0]         cfg_sb,
  input  logic [RW-1:0]           road,
  output logic [NL-1:0][SB_W-1:0] sb_out
);
  localparam int NR = 1 << RW;

  logic [SB_W-1:0] tbl [NL][NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++)
        for (int r = 0; r < NR; r++)
          tbl[l][r] <= '0;
    end else if (cfg_we && (int'(cfg_layer) < NL)) begin
      tbl[int'(cfg_layer)][cfg_road] <= cfg_sb;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_rd
    assign sb_out[l] = tbl[l][road];
  end
endmodule

// File: rtl/hit_road_organizer.sv
module hit_road_organizer #(
  parameter int NLAYERS  = 2,
  parameter int COORD_W  = 8,
  parameter int SB_SHIFT = 2,
  parameter int ROAD_W   = 4,
  parameter int STORE_AW = 4,
  parameter int FIFO_AW  = 3,
  localparam int LW   = (NLAYERS > 1) ? $clog2(NLAYERS) : 1,
  localparam int SB_W = COORD_W - SB_SHIFT,
  localparam int PW   = ((LW + COORD_W) > ROAD_W) ? (LW + COORD_W) : ROAD_W
) (
  input  logic               clk,
  input  logic               hit_clk,
  input  logic               rst_n,
  input  logic               hit_valid,
  output logic               hit_ready,
  input  logic               hit_eoe,
  input  logic [LW-1:0]      hit_layer,
  input  logic [COORD_W-1:0] hit_coord,
  output logic               sb_valid,
  input  logic               sb_ready,
  output logic               sb_eoe,
  output logic [LW-1:0]      sb_layer,
  output logic [SB_W-1:0]    sb_bin,
  input  logic               road_valid,
  output logic               road_ready,
  input  logic               road_end,
  input  logic [ROAD_W-1:0]  road_id,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic               pkt_hdr,
  output logic               pkt_last,
  output logic [PW-1:0]      pkt_data,
  input  logic               cfg_we,
  input  logic [ROAD_W-1:0]  cfg_road,
  input  logic [LW-1:0]      cfg_layer,
  input  logic [SB_W-1:0]    cfg_sb
);
  import hdo_pkg::*;

  localparam int FW = 1 + LW + COORD_W;

  hdo_state_e              state;
  logic [FW-1:0]           f_data;
  logic                    f_valid, pop;
  logic                    f_eoe;
  logic [LW-1:0]           f_layer;
  logic [COORD_W-1:0]      f_coord;
  logic [ROAD_W-1:0]       road_r;
  logic [LW-1:0]           layer_r;
  logic [STORE_AW-1:0]     ptr_r;
  logic [NLAYERS-1:0][SB_W-1:0]     exp_sb;
  logic [NLAYERS-1:0]               q_v;
  logic [NLAYERS-1:0][STORE_AW-1:0] q_ptr;
  logic [COORD_W-1:0]      rd_coord;
  logic                    rd_next_v;
  logic [STORE_AW-1:0]     rd_next;
  logic                    st_full;
  logic                    any_hits, later_hits;

  hdo_cdc_fifo #(.W(FW), .AW(FIFO_AW)) u_in_fifo (
    .wclk(hit_clk), .rclk(clk), .rst_n(rst_n),
    .wr_valid(hit_valid), .wr_ready(hit_ready),
    .wr_data({hit_eoe, hit_layer, hit_coord}),
    .rd_valid(f_valid), .rd_pop(pop), .rd_data(f_data)
  );

  assign f_eoe   = f_data[FW-1];
  assign f_layer = f_data[COORD_W +: LW];
  assign f_coord = f_data[COORD_W-1:0];
  assign pop     = ((state == ST_IDLE) || (state == ST_FILL)) && f_valid &&
                   (!sb_valid || sb_ready);

  hdo_hit_store #(
    .NL(NLAYERS), .LW(LW), .SB_W(SB_W), .CW(COORD_W), .AW(STORE_AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_CLEAR),
    .wr_en(pop && !f_eoe), .wr_layer(f_layer),
    .wr_sb(f_coord[COORD_W-1:SB_SHIFT]), .wr_coord(f_coord),
    .full(st_full),
    .q_sb(exp_sb), .q_v(q_v), .q_ptr(q_ptr),
    .rd_ptr(ptr_r), .rd_coord(rd_coord), .rd_next_v(rd_next_v), .rd_next(rd_next)
  );

  hdo_road_lut #(.NL(NLAYERS), .LW(LW), .SB_W(SB_W), .RW(ROAD_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_road(cfg_road),
    .cfg_layer(cfg_layer), .cfg_sb(cfg_sb), .road(road_r), .sb_out(exp_sb)
  );

  always_comb begin
    later_hits = 1'b0;
    for (int l = 0; l < NLAYERS; l++)
      if ((l > int'(layer_r)) && q_v[l]) later_hits = 1'b1;
  end
  assign any_hits = |q_v;

  assign road_ready = (state == ST_WAIT);
  assign pkt_valid  = (state == ST_HDR) || (state == ST_HIT);
  assign pkt_hdr    = (state == ST_HDR);
  assign pkt_last   = (state == ST_HDR) ? !any_hits : (!rd_next_v && !later_hits);
  assign pkt_data   = (state == ST_HDR) ? PW'(road_r) : PW'({layer_r, rd_coord});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_valid <= 1'b0;
      sb_eoe   <= 1'b0;
      sb_layer <= '0;
      sb_bin   <= '0;
    end else if (pop) begin
      sb_valid <= 1'b1;
      sb_eoe   <= f_eoe;
      sb_layer <= f_layer;
      sb_bin   <= f_coord[COORD_W-1:SB_SHIFT];
    end else if (sb_ready) begin
      sb_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      road_r  <= '0;
      layer_r <= '0;
      ptr_r   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_FILL: begin
          if (pop) state <= f_eoe ? ST_WAIT : ST_FILL;
        end
        ST_WAIT: begin
          if (road_valid) begin
            if (road_end) begin
              state <= ST_CLEAR;
            end else begin
              road_r <= road_id;
              state  <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (pkt_ready) begin
            layer_r <= '0;
            state   <= any_hits ? ST_SEEK : ST_WAIT;
          end
        end
        ST_SEEK: begin
          if (q_v[layer_r]) begin
            ptr_r <= q_ptr[layer_r];
            state <= ST_HIT;
          end else if (later_hits) begin
            layer_r <= layer_r + 1'b1;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_HIT: begin
          if (pkt_ready) begin
            if (rd_next_v) begin
              ptr_r <= rd_next;
            end else if (later_hits) begin
              layer_r <= layer_r + 1'b1;
              state   <= ST_SEEK;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_CLEAR: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  logic unused_full;
  assign unused_full = st_full;
endmodule

// File: rtl/hit_road_organizer_chk.sv
module hit_road_organizer_chk #(
  parameter int LW   = 1,
  parameter int SB_W = 6,
  parameter int PW   = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sb_valid,
  input logic            sb_ready,
  input logic            sb_eoe,
  input logic [LW-1:0]   sb_layer,
  input logic [SB_W-1:0] sb_bin,
  input logic            road_ready,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input logic            pkt_hdr,
  input logic            pkt_last,
  input logic [PW-1:0]   pkt_data
);
  // R3
  sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid && !sb_ready |=> sb_valid && $stable(sb_eoe) && $stable(sb_layer) && $stable(sb_bin));

  // R10
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_hdr) && $stable(pkt_last) && $stable(pkt_data));

  // R6
  pkt_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && pkt_last |=> !pkt_valid);

  // R5
  pkt_no_mid_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && !pkt_last |=> !(pkt_valid && pkt_hdr));

  // R11
  road_vs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(road_ready && pkt_valid));
endmodule

bind hit_road_organizer hit_road_organizer_chk #(.LW(LW), .SB_W(SB_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_eoe(sb_eoe),
  .sb_layer(sb_layer), .sb_bin(sb_bin),
  .road_ready(road_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr),
  .pkt_last(pkt_last), .pkt_data(pkt_data)
);

// File: tb/tb_hit_road_organizer.sv
module tb_hit_road_organizer;
  logic clk = 1'b0, hit_clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;
  always #7 hit_clk = ~hit_clk;

  logic       hit_valid = 0, hit_ready, hit_eoe = 0;
  logic [0:0] hit_layer = '0;
  logic [7:0] hit_coord = '0;
  logic       sb_valid, sb_ready = 1, sb_eoe;
  logic [0:0] sb_layer;
  logic [5:0] sb_bin;
  logic       road_valid = 0, road_ready, road_end = 0;
  logic [3:0] road_id = '0;
  logic       pkt_valid, pkt_ready = 1, pkt_hdr, pkt_last;
  logic [8:0] pkt_data;
  logic       cfg_we = 0;
  logic [3:0] cfg_road = '0;
  logic [0:0] cfg_layer = '0;
  logic [5:0] cfg_sb = '0;

  hit_road_organizer dut (
    .clk(clk), .hit_clk(hit_clk), .rst_n(rst_n),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_eoe(hit_eoe),
    .hit_layer(hit_layer), .hit_coord(hit_coord),
    .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_eoe(sb_eoe),
    .sb_layer(sb_layer), .sb_bin(sb_bin),
    .road_valid(road_valid), .road_ready(road_ready), .road_end(road_end), .road_id(road_id),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr),
    .pkt_last(pkt_last), .pkt_data(pkt_data),
    .cfg_we(cfg_we), .cfg_road(cfg_road), .cfg_layer(cfg_layer), .cfg_sb(cfg_sb)
  );

  int checks = 0, failures = 0;
  int sb_n = 0, pkt_n = 0, last_n = 0;
  logic [7:0]  sb_log  [64];
  logic [10:0] pkt_log [64];

  // {layer, coord, expected bin}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 8'h40, 6'h10}, {1'b1, 8'h83, 6'h20}, {1'b0, 8'h43, 6'h10}, {1'b1, 8'hFF, 6'h3F},
    {1'b0, 8'h00, 6'h00}, {1'b1, 8'h80, 6'h20}, {1'b0, 8'h13, 6'h04}, {1'b1, 8'h7C, 6'h1F}
  };
  // {hdr, last, data}
  localparam logic [10:0] EXP_A [10] = '{
    {2'b10, 9'h001}, {2'b00, 9'h043}, {2'b00, 9'h040}, {2'b00, 9'h180}, {2'b01, 9'h183},
    {2'b10, 9'h002}, {2'b01, 9'h013},
    {2'b10, 9'h005}, {2'b01, 9'h1FF},
    {2'b11, 9'h007}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_valid && sb_ready && sb_n < 64) begin
      sb_log[sb_n] = {sb_eoe, sb_layer, sb_bin};
      sb_n++;
    end
    if (rst_n && pkt_valid && pkt_ready && pkt_n < 64) begin
      pkt_log[pkt_n] = {pkt_hdr, pkt_last, pkt_data};
      pkt_n++;
      if (pkt_last) last_n++;
    end
  end

  task automatic send_hit(input logic l, input logic [7:0] c, input logic e);
    @(posedge hit_clk); #1;
    hit_valid = 1; hit_layer = l; hit_coord = c; hit_eoe = e;
    do @(negedge hit_clk); while (!hit_ready);
    @(posedge hit_clk); #1;
    hit_valid = 0;
  endtask

  task automatic send_road(input logic [3:0] id, input logic e);
    @(posedge clk); #1;
    road_valid = 1; road_id = id; road_end = e;
    do @(negedge clk); while (!road_ready);
    @(posedge clk); #1;
    road_valid = 0;
  endtask

  task automatic cfg(input logic [3:0] r, input logic l, input logic [5:0] s);
    @(posedge clk); #1;
    cfg_we = 1; cfg_road = r; cfg_layer = l; cfg_sb = s;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(hit_ready === 1'b1, "R12 hit_ready", 32'(hit_ready), 1);
    chk(sb_valid === 1'b0, "R12 sb_valid", 32'(sb_valid), 0);
    chk(road_ready === 1'b0, "R12 road_ready", 32'(road_ready), 0);
    chk(pkt_valid === 1'b0, "R12 pkt_valid", 32'(pkt_valid), 0);

    // R4 road table
    cfg(4'd1, 1'b0, 6'h10); cfg(4'd1, 1'b1, 6'h20);
    cfg(4'd2, 1'b0, 6'h04); cfg(4'd2, 1'b1, 6'h05);
    cfg(4'd5, 1'b0, 6'h3F); cfg(4'd5, 1'b1, 6'h3F);
    cfg(4'd7, 1'b0, 6'h21); cfg(4'd7, 1'b1, 6'h00);
    cfg(4'd9, 1'b0, 6'h01); cfg(4'd9, 1'b1, 6'h3E);

    // Event A: table-driven hits, super-bin stream throttled (R3)
    fork
      begin
        repeat (50) begin @(posedge clk); #1 sb_ready = ~sb_ready; end
        @(posedge clk); #1 sb_ready = 1;
      end
      begin
        for (int i = 0; i < 8; i++) send_hit(VEC[i][14], VEC[i][13:6], 1'b0);
        send_hit(1'b0, 8'h00, 1'b1);
      end
    join
    wait (sb_n == 9);
    for (int i = 0; i < 8; i++)
      chk(sb_log[i] == {1'b0, VEC[i][14], VEC[i][5:0]}, "R1 super-bin word",
          32'(sb_log[i]), 32'({1'b0, VEC[i][14], VEC[i][5:0]}));
    chk(sb_log[8][7] === 1'b1, "R2 end-of-event marker", 32'(sb_log[8][7]), 1);
    @(negedge clk);
    chk(road_ready === 1'b1, "R2 road_ready after marker", 32'(road_ready), 1);

    // Readout of A with packet back-pressure, next event's hits sent meanwhile (R10, R11)
    fork
      begin
        send_hit(1'b0, 8'h41, 1'b0);
        send_hit(1'b0, 8'h00, 1'b1);
      end
      begin
        repeat (60) begin @(posedge clk); #1 pkt_ready = ~pkt_ready; end
        @(posedge clk); #1 pkt_ready = 1;
      end
      begin
        send_road(4'd1, 1'b0); wait (last_n == 1);
        send_road(4'd2, 1'b0); wait (last_n == 2);
        send_road(4'd5, 1'b0); wait (last_n == 3);
        send_road(4'd7, 1'b0); wait (last_n == 4);
      end
    join
    chk(pkt_n == 10, "R5 word count event A", 32'(pkt_n), 10);
    for (int i = 0; i < 10; i++)
      chk(pkt_log[i] == EXP_A[i], "R5 R6 R7 packet word", 32'(pkt_log[i]), 32'(EXP_A[i]));
    repeat (10) @(negedge clk);
    chk(sb_n == 9, "R11 new hits held during readout", 32'(sb_n), 9);
    send_road(4'd0, 1'b1);
    wait (sb_n == 11);
    chk(sb_log[9] == 8'h10, "R11 held hit forwarded", 32'(sb_log[9]), 32'h10);
    chk(sb_log[10][7] === 1'b1, "R11 held marker forwarded", 32'(sb_log[10][7]), 1);

    // Event B: store cleared (R8)
    send_road(4'd1, 1'b0); wait (last_n == 5);
    chk(pkt_n == 12, "R8 word count after clear", 32'(pkt_n), 12);
    chk(pkt_log[10] == {2'b10, 9'h001}, "R8 header", 32'(pkt_log[10]), 32'({2'b10, 9'h001}));
    chk(pkt_log[11] == {2'b01, 9'h041}, "R8 only new hit", 32'(pkt_log[11]), 32'({2'b01, 9'h041}));
    send_road(4'd0, 1'b1);

    // Event C: store capacity (R9)
    for (int i = 0; i < 17; i++) send_hit(1'b0, 8'(4 + (i % 4)), 1'b0);
    send_hit(1'b0, 8'h00, 1'b1);
    wait (sb_n == 29);
    chk(sb_log[27] == 8'h01, "R9 overflow hit still forwarded", 32'(sb_log[27]), 32'h01);
    send_road(4'd9, 1'b0); wait (last_n == 6);
    chk(pkt_n == 29, "R9 stored hits capped", 32'(pkt_n), 29);
    chk(pkt_log[12] == {2'b10, 9'h009}, "R9 header", 32'(pkt_log[12]), 32'({2'b10, 9'h009}));
    chk(pkt_log[13] == {2'b00, 9'h007}, "R9 newest stored first", 32'(pkt_log[13]), 32'({2'b00, 9'h007}));
    chk(pkt_log[28] == {2'b01, 9'h004}, "R9 oldest last", 32'(pkt_log[28]), 32'({2'b01, 9'h004}));
    send_road(4'd0, 1'b1);
    repeat (5) @(negedge clk);
    chk(pkt_valid === 1'b0, "R6 idle after event", 32'(pkt_valid), 0);

    summary();
    $finish;
  end
endmodule